// File: doc/BRIEF.md
# Hold-Request Conversion Scheduler

This block sits in front of a dual converter that is shared by three channel pairs (A, B and C). Each pair has an active-low hold line. A falling edge on a hold line requests a conversion of that pair. The block samples the hold lines on the falling clock edge, keeps an ordered waiting list of the pairs that have been requested but not yet converted, and runs one conversion at a time. When several pairs arrive in the same cycle, they enter the list in fixed order: A, then B, then C.

For each conversion the block drives an active-low busy output for the conversion phase. It then latches the two results of the pair and emits a one-cycle write strobe that carries the pair index and both data words, for use by a result buffer. The converter datapath is a stub: the two data words present on the stub inputs when the result latches are the results. A pair that is waiting or converting ignores further edges on its hold line until its result has latched. An asynchronous active-low reset clears all scheduled and running work.

Top module: `hold_sched`

## Requirements
- R1: While reset is low, and in the first cycle after it, busy_n is 1 and wr_stb is 0. Reset cancels the running conversion and every waiting pair, and no strobe follows from them. After reset, a new hold edge is served normally.
- R2: A hold falling edge is sampled on a falling clock edge. If the scheduler is idle, the conversion starts on the next rising edge, so busy_n is 0 in the cycle that follows.
- R3: busy_n stays 0 for exactly 13 consecutive cycles per conversion, then returns to 1.
- R4: wr_stb is high for exactly one cycle, in the first cycle in which busy_n is back at 1. In that cycle wr_pair gives the pair (0 = A, 1 = B, 2 = C), and wr_data0 and wr_data1 hold the stub inputs as they were in the last busy cycle.
- R5: A waiting pair starts its conversion exactly 16 cycles after the start of the previous conversion.
- R6: Pairs whose hold edges are sampled in the same cycle are converted in the order A, B, C.
- R7: Pairs sampled in different cycles are converted in the order of arrival, whatever their letters.
- R8: A hold edge on a pair that is waiting or converting is ignored. Once that pair's result has latched, a new edge on it is accepted.
- R9: A hold line that stays low starts no further conversions.
- R10: A request sampled at the same rising edge at which a waiting pair starts is placed behind that pair and is not lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold_n | input | 3 | Active-low hold lines, bit 0 = A, bit 1 = B, bit 2 = C |
| stub_data0 | input | 12 | Stub result for the pair's first channel |
| stub_data1 | input | 12 | Stub result for the pair's second channel |
| busy_n | output | 1 | Low while a conversion is in its conversion phase |
| wr_stb | output | 1 | One-cycle result write strobe |
| wr_pair | output | 2 | Pair index for the strobe |
| wr_data0 | output | 12 | Latched first result |
| wr_data1 | output | 12 | Latched second result |

## Verification
Two things can land on the same rising edge: a waiting pair can leave the head of the list to start converting, and a freshly sampled hold edge can join the list. The bench provokes this by timing a pair C edge so that it is sampled in the cycle just before a queued pair A starts. The run passes only if the start times come out 16 cycles apart and the order is B, A, C. The same ordering logic is also exercised when all three hold lines fall together. In that case the order of the write strobes decides the result.

// File: rtl/hold_sched_pkg.sv
package hold_sched_pkg;
    localparam int NPAIR = 3;
    localparam int PW    = $clog2(NPAIR);
    typedef logic [PW-1:0] pair_t;
endpackage

// File: rtl/hold_sampler.sv
module hold_sampler #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] hold_n,
    output logic [N-1:0] fall
);
    logic [N-1:0] smp_q;
    logic [N-1:0] prev_d, prev_q;

    // hold lines are taken on the falling clock edge
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) smp_q <= '1;
        else        smp_q <= hold_n;
    end

    always_comb begin
        prev_d = smp_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= prev_d;
    end

    assign fall = prev_q & ~smp_q;

    // R2: a detected edge cannot repeat in the next cycle without a rise
    p_single_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fall != '0) |=> ((fall & $past(fall)) == '0));
endmodule

// File: rtl/pair_queue.sv
module pair_queue
    import hold_sched_pkg::*;
#(
    parameter int DEPTH = NPAIR
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPAIR-1:0] fall,
    input  logic             pop,
    input  logic             rel,
    input  pair_t            rel_pair,
    output logic             head_vld,
    output pair_t            head
);
    localparam int CNTW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][PW-1:0] slot;
        logic [CNTW-1:0]          cnt;
        logic [NPAIR-1:0]         pend;
    } q_state_t;

    q_state_t st_d, st_q;
    logic [NPAIR-1:0] push;
    logic [NPAIR-1:0] rel_mask;
    logic [DEPTH-1:0][PW-1:0] tmp_slot;
    logic [CNTW-1:0] tmp_cnt;

    always_comb begin
        push     = fall & ~st_q.pend;
        rel_mask = rel ? (NPAIR'(1) << rel_pair) : '0;
        tmp_slot = st_q.slot;
        tmp_cnt  = st_q.cnt;
        // new arrivals join behind older entries, lowest index first
        for (int i = 0; i < NPAIR; i++) begin
            if (push[i] && tmp_cnt < CNTW'(DEPTH)) begin
                tmp_slot[tmp_cnt] = PW'(i);
                tmp_cnt           = tmp_cnt + 1'b1;
            end
        end
        head_vld = (tmp_cnt != '0);
        head     = tmp_slot[0];
        if (pop && head_vld) begin
            for (int k = 0; k < DEPTH - 1; k++) tmp_slot[k] = tmp_slot[k+1];
            tmp_slot[DEPTH-1] = '0;
            tmp_cnt           = tmp_cnt - 1'b1;
        end
        st_d.slot = tmp_slot;
        st_d.cnt  = tmp_cnt;
        st_d.pend = (st_q.pend | push) & ~rel_mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R8: list never exceeds its depth
    p_depth_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNTW'(DEPTH));
    // R8: every listed pair is still marked pending
    p_listed_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(st_q.pend) >= int'(st_q.cnt));
    // R5: a pop is only requested when something is available
    p_pop_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> head_vld);
endmodule

// File: rtl/conv_timer.sv
module conv_timer
    import hold_sched_pkg::*;
#(
    parameter int DATA_W   = 12,
    parameter int CONV_CYC = 16,
    parameter int BUSY_CYC = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              head_vld,
    input  pair_t             head,
    input  logic [DATA_W-1:0] stub0,
    input  logic [DATA_W-1:0] stub1,
    output logic              pop,
    output logic              rel,
    output pair_t             rel_pair,
    output logic              busy_n,
    output logic              wr,
    output pair_t             wr_pair,
    output logic [DATA_W-1:0] d0,
    output logic [DATA_W-1:0] d1
);
    localparam int CW = $clog2(CONV_CYC);

    typedef struct packed {
        logic              active;
        logic [CW-1:0]     cnt;
        pair_t             pair;
        logic              busy_n;
        logic              wr;
        pair_t             wr_pair;
        logic [DATA_W-1:0] d0;
        logic [DATA_W-1:0] d1;
    } t_state_t;

    t_state_t st_d, st_q;
    logic can_start;
    logic latch;

    always_comb begin
        st_d      = st_q;
        st_d.wr   = 1'b0;
        can_start = !st_q.active || (st_q.cnt == CW'(CONV_CYC - 1));
        latch     = st_q.active && (st_q.cnt == CW'(BUSY_CYC - 1));
        pop       = can_start && head_vld;
        if (st_q.active) st_d.cnt = st_q.cnt + 1'b1;
        if (latch) begin
            st_d.wr      = 1'b1;
            st_d.wr_pair = st_q.pair;
            st_d.d0      = stub0;
            st_d.d1      = stub1;
        end
        if (can_start) begin
            st_d.active = head_vld;
            st_d.cnt    = '0;
            if (head_vld) st_d.pair = head;
        end
        st_d.busy_n = !(st_d.active && (st_d.cnt < CW'(BUSY_CYC)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.busy_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign rel      = latch;
    assign rel_pair = st_q.pair;
    assign busy_n   = st_q.busy_n;
    assign wr       = st_q.wr;
    assign wr_pair  = st_q.wr_pair;
    assign d0       = st_q.d0;
    assign d1       = st_q.d1;

    // R4: strobe lasts one cycle
    p_strobe_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> !wr);
    // R4: strobe coincides with busy back high
    p_strobe_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr |-> busy_n);
    // R3: busy stays high in the cycle after the strobe
    p_busy_after_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> busy_n);
    // R5: no new start during acquisition before the last slot
    p_acq_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && st_q.cnt >= CW'(BUSY_CYC) && st_q.cnt < CW'(CONV_CYC - 1))
        |=> busy_n);
endmodule

// File: rtl/hold_sched.sv
module hold_sched
    import hold_sched_pkg::*;
#(
    parameter int DATA_W   = 12,
    parameter int CONV_CYC = 16,
    parameter int BUSY_CYC = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        hold_n,
    input  logic [DATA_W-1:0] stub_data0,
    input  logic [DATA_W-1:0] stub_data1,
    output logic              busy_n,
    output logic              wr_stb,
    output logic [1:0]        wr_pair,
    output logic [DATA_W-1:0] wr_data0,
    output logic [DATA_W-1:0] wr_data1
);
    logic [NPAIR-1:0] fall;
    logic  head_vld, pop, rel;
    pair_t head, rel_pair, wr_pair_i;

    hold_sampler #(.N(NPAIR)) u_smp (
        .clk(clk), .rst_n(rst_n), .hold_n(hold_n), .fall(fall)
    );

    pair_queue #(.DEPTH(NPAIR)) u_q (
        .clk(clk), .rst_n(rst_n), .fall(fall), .pop(pop),
        .rel(rel), .rel_pair(rel_pair), .head_vld(head_vld), .head(head)
    );

    conv_timer #(.DATA_W(DATA_W), .CONV_CYC(CONV_CYC), .BUSY_CYC(BUSY_CYC)) u_tmr (
        .clk(clk), .rst_n(rst_n), .head_vld(head_vld), .head(head),
        .stub0(stub_data0), .stub1(stub_data1), .pop(pop), .rel(rel),
        .rel_pair(rel_pair), .busy_n(busy_n), .wr(wr_stb), .wr_pair(wr_pair_i),
        .d0(wr_data0), .d1(wr_data1)
    );

    assign wr_pair = wr_pair_i;

    // R4: reported pair index is always a real pair
    p_pair_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> (wr_pair < 2'(NPAIR)));
endmodule

// File: tb/hold_sched_tb.sv
module hold_sched_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  hold_n = 3'b111;
    logic [11:0] stub0 = 12'h5A3;
    logic [11:0] stub1 = 12'hC3E;
    logic        busy_n, wr_stb;
    logic [1:0]  wr_pair;
    logic [11:0] wr_data0, wr_data1;

    int total = 0, fails = 0, cyc = 0;
    int ev_n = 0, bf_n = 0, low_n = 0;
    int ev_pair[8], ev_t[8], ev_d0[8], ev_d1[8], bf_t[8];
    logic last_busy = 1'b1;

    always #5 clk = ~clk;

    hold_sched dut_i (
        .clk(clk), .rst_n(rst_n), .hold_n(hold_n), .stub_data0(stub0),
        .stub_data1(stub1), .busy_n(busy_n), .wr_stb(wr_stb), .wr_pair(wr_pair),
        .wr_data0(wr_data0), .wr_data1(wr_data1)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #3;
        cyc++;
        if (wr_stb && ev_n < 8) begin
            ev_pair[ev_n] = int'(wr_pair); ev_t[ev_n] = cyc;
            ev_d0[ev_n] = int'(wr_data0); ev_d1[ev_n] = int'(wr_data1);
            ev_n++;
        end
        if (!busy_n) low_n++;
        if (!busy_n && last_busy && bf_n < 8) begin
            bf_t[bf_n] = cyc; bf_n++;
        end
        last_busy = busy_n;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic clear_log();
        ev_n = 0; bf_n = 0; low_n = 0;
    endtask

    task automatic t_reset_state();
        check(busy_n === 1'b1, "R1", "busy_n after reset", int'(busy_n), 1);
        check(wr_stb === 1'b0, "R1", "wr_stb after reset", int'(wr_stb), 0);
    endtask

    task automatic t_single();
        int s;
        clear_log();
        hold_n = 3'b101;
        tick(); s = cyc;
        check(busy_n === 1'b0, "R2", "busy_n one edge after hold", int'(busy_n), 0);
        ticks(4);
        stub0 = 12'h7E1; stub1 = 12'h0B4;
        ticks(20);
        hold_n = 3'b111;
        check(low_n == 13, "R3", "busy low cycles", low_n, 13);
        check(ev_n == 1, "R4", "strobe count", ev_n, 1);
        check(ev_t[0] - s == 13, "R4", "strobe offset", ev_t[0] - s, 13);
        check(ev_pair[0] == 1, "R4", "pair index B", ev_pair[0], 1);
        check(ev_d0[0] == 'h7E1, "R4", "data0 at latch", ev_d0[0], 'h7E1);
        check(ev_d1[0] == 'h0B4, "R4", "data1 at latch", ev_d1[0], 'h0B4);
        ticks(3);
    endtask

    task automatic t_same_cycle();
        clear_log();
        hold_n = 3'b000;
        ticks(55);
        hold_n = 3'b111;
        check(ev_n == 3, "R6", "strobes for three pairs", ev_n, 3);
        check(ev_pair[0] == 0, "R6", "first pair", ev_pair[0], 0);
        check(ev_pair[1] == 1, "R6", "second pair", ev_pair[1], 1);
        check(ev_pair[2] == 2, "R6", "third pair", ev_pair[2], 2);
        check(bf_t[1] - bf_t[0] == 16, "R5", "start spacing 1", bf_t[1] - bf_t[0], 16);
        check(bf_t[2] - bf_t[1] == 16, "R5", "start spacing 2", bf_t[2] - bf_t[1], 16);
        check(low_n == 39, "R3", "busy low over three", low_n, 39);
        ticks(3);
    endtask

    task automatic t_arrival_order();
        clear_log();
        hold_n = 3'b101;
        tick();
        hold_n = 3'b000;
        ticks(55);
        hold_n = 3'b111;
        check(ev_n == 3, "R7", "strobe count", ev_n, 3);
        check(ev_pair[0] == 1 && ev_pair[1] == 0 && ev_pair[2] == 2, "R7",
              "order B,A,C (pair0*100+pair1*10+pair2)",
              ev_pair[0]*100 + ev_pair[1]*10 + ev_pair[2], 102);
        ticks(3);
    endtask

    task automatic t_push_at_pop();
        int s;
        clear_log();
        hold_n = 3'b101;
        tick(); s = cyc;
        hold_n = 3'b100;
        while (cyc < s + 15) tick();
        hold_n = 3'b000;
        ticks(50);
        hold_n = 3'b111;
        check(bf_n == 3, "R10", "starts", bf_n, 3);
        check(bf_t[1] == s + 16, "R10", "A start", bf_t[1] - s, 16);
        check(bf_t[2] == s + 32, "R10", "C start behind A", bf_t[2] - s, 32);
        check(ev_pair[2] == 2, "R10", "last pair C", ev_pair[2], 2);
        ticks(3);
    endtask

    task automatic t_repeat();
        int s;
        clear_log();
        hold_n = 3'b110;
        tick(); s = cyc;
        for (int i = 0; i < 4; i++) begin
            hold_n = 3'b111; tick();
            hold_n = 3'b110; tick();
        end
        hold_n = 3'b111;
        while (cyc < s + 13) tick();
        hold_n = 3'b110;
        ticks(40);
        hold_n = 3'b111;
        check(ev_n == 2, "R8", "strobes (repeat ignored, late edge taken)", ev_n, 2);
        check(bf_n >= 2 && bf_t[1] == s + 16, "R8", "second start offset",
              (bf_n >= 2) ? bf_t[1] - s : -1, 16);
        ticks(3);
    endtask

    task automatic t_held_low();
        clear_log();
        hold_n = 3'b011;
        ticks(50);
        check(ev_n == 1, "R9", "strobes with C held low", ev_n, 1);
        check(bf_n == 1, "R9", "starts with C held low", bf_n, 1);
        hold_n = 3'b111;
        ticks(3);
    endtask

    task automatic t_reset_mid();
        clear_log();
        hold_n = 3'b001;
        ticks(6);
        rst_n = 1'b0;
        #1;
        check(busy_n === 1'b1, "R1", "busy_n in reset", int'(busy_n), 1);
        check(wr_stb === 1'b0, "R1", "wr_stb in reset", int'(wr_stb), 0);
        hold_n = 3'b111;
        ticks(2);
        rst_n = 1'b1;
        clear_log();
        ticks(50);
        check(ev_n == 0, "R1", "strobes after cancel", ev_n, 0);
        check(bf_n == 0, "R1", "starts after cancel", bf_n, 0);
        hold_n = 3'b110;
        tick();
        check(busy_n === 1'b0, "R1", "start after reset", int'(busy_n), 0);
        hold_n = 3'b111;
        ticks(20);
        check(ev_n == 1 && ev_pair[0] == 0, "R1", "pair A after reset",
              (ev_n == 1) ? ev_pair[0] : -1, 0);
    endtask

    initial begin
        #1_000_000;
        fails++; total++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        ticks(3);
        t_reset_state();
        rst_n = 1'b1;
        tick();
        t_reset_state();
        ticks(2);
        t_single();
        t_same_cycle();
        t_arrival_order();
        t_push_at_pop();
        t_repeat();
        t_held_low();
        t_reset_mid();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule